// File: doc/BRIEF.md
# Destination-ID Stream Router with Local Broadcast

This block takes one incoming data stream that carries, in a fixed order, the bias values, the filter weights and the feature-map values for one layer of a convolution engine. It steers every accepted beat to exactly one of several target buffers. There is no address decoding. A destination ID register names the single buffer allowed to take data, and every target compares that register with its own fixed ID. The ID starts at the bias buffer. Each burst ends with the last-beat marker, and each such end moves the ID to the next target. The weight buffers come next in turn, then the global image buffer. After that the router goes idle and raises a load-complete flag. All targets share one write address, which restarts at zero for every new target.

The second function is independent of the first. It distributes global image words to a set of local image buffers. Each word carries a local ID. It passes through a tree of registers in which no register drives more than a set number of others. Only the local buffer whose ID matches raises its write strobe. Every local buffer sees the data word.

Top module: `stream_id_router`

## Requirements
- R1: Target IDs are fixed. The bias buffer is ID 1 and drives `wr_en` bit 0. Weight buffer n (0 to 63) is ID n+2 and drives bit n+1. The global image buffer is ID 66 and drives bit 65.
- R2: While idle (`cur_id` = 0), a high `load_start` at a clock edge sets `cur_id` to 1 and clears `load_done`. A `load_start` seen while a load is active has no effect.
- R3: A beat is accepted when `s_tvalid` and `s_tready` are both high. In the cycle of an accepted beat, exactly the `wr_en` bit of the target whose ID equals `cur_id` is high, and `wr_data` equals `s_tdata`. In any other cycle `wr_en` is all zero.
- R4: `wr_addr` is 0 for the first beat of each target. It increments by one after each accepted beat without `s_tlast` and wraps at 2^AW. It returns to 0 after an accepted beat with `s_tlast`.
- R5: `cur_id` increases by one after an accepted beat with `s_tlast` when `cur_id` is below 66. In every other active cycle it holds its value.
- R6: `s_tready` is high when `cur_id` is nonzero and the `tgt_full` bit of the selected target is low. It is low while that bit is high and while idle. The `tgt_full` bits of unselected targets have no effect.
- R7: After an accepted beat with `s_tlast` at `cur_id` 66, `cur_id` becomes 0 and `load_done` becomes 1. `load_done` stays 1 until the next accepted `load_start`.
- R8: A global image word sampled with `gib_valid` high and `gib_lid` = k raises `lib_we` bit k-1 exactly 3 cycles later, when k is 1 to 64, with the default tree depth. `gib_lid` values 0 and above 64 raise no strobe. No strobe rises without such a word.
- R9: Every local data slot `lib_data[j*16 +: 16]` equals the `gib_data` sampled 3 cycles earlier, whether or not a strobe is raised. No register in the broadcast tree drives more than FAN (8) registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_start | input | 1 | Begin a layer load (used only while idle) |
| s_tdata | input | 16 | Stream data |
| s_tvalid | input | 1 | Stream beat valid |
| s_tlast | input | 1 | Last beat of the current target's burst |
| s_tready | output | 1 | Stream ready |
| tgt_full | input | 66 | Per-target full indication, bit k for ID k+1 |
| wr_en | output | 66 | One-hot target write strobe, bit k for ID k+1 |
| wr_addr | output | 12 | Shared write address within the current target |
| wr_data | output | 16 | Write data to the targets |
| cur_id | output | 7 | Current destination ID, 0 when idle |
| load_done | output | 1 | Load complete flag |
| gib_valid | input | 1 | Global image word valid |
| gib_lid | input | 7 | Local buffer ID for the global image word |
| gib_data | input | 16 | Global image word |
| lib_we | output | 64 | Local buffer write strobes, bit j for local ID j+1 |
| lib_data | output | 1024 | Local buffer data, 16 bits per buffer |

## Verification
Three things can fall in one cycle: the closing beat of a burst, a full indication on the selected target, and a `load_start` request. The bench stalls the selected target at random while bursts run. It raises `load_start` during the final image beat, so a start request meets the step back to idle. The expected rule is that the ID advances only on an accepted closing beat, that the start in that cycle is ignored, and that `load_done` appears the next cycle with the router idle. Broadcast words with random local IDs, including out-of-range ones, run at the same time as the stream. This shows that the two paths never disturb each other. Every port is compared against a behavioural model on every clock.

// File: rtl/stream_id_router.sv
`timescale 1ns/1ps
module stream_id_router #(
  parameter int DW  = 16,
  parameter int NW  = 64,
  parameter int NL  = 64,
  parameter int FAN = 8,
  parameter int AW  = 12
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_start,
  input  logic [DW-1:0]            s_tdata,
  input  logic                     s_tvalid,
  input  logic                     s_tlast,
  output logic                     s_tready,
  input  logic [NW+1:0]            tgt_full,
  output logic [NW+1:0]            wr_en,
  output logic [AW-1:0]            wr_addr,
  output logic [DW-1:0]            wr_data,
  output logic [$clog2(NW+3)-1:0]  cur_id,
  output logic                     load_done,
  input  logic                     gib_valid,
  input  logic [$clog2(NL+1)-1:0]  gib_lid,
  input  logic [DW-1:0]            gib_data,
  output logic [NL-1:0]            lib_we,
  output logic [NL*DW-1:0]         lib_data
);

  localparam int NT  = NW + 2;
  localparam int IDW = $clog2(NT + 1);
  localparam int LW  = $clog2(NL + 1);

  function automatic int tree_depth(int n, int f);
    int c = 1;
    int d = 0;
    while (c < n) begin
      c = c * f;
      d++;
    end
    return d;
  endfunction

  localparam int L   = tree_depth(NL, FAN);
  localparam int LAT = L + 1;

  function automatic int ipow(int b, int e);
    int r = 1;
    for (int i = 0; i < e; i++) r = r * b;
    return r;
  endfunction

  function automatic int lvl_nodes(int l);
    return (NL + ipow(FAN, L - l) - 1) / ipow(FAN, L - l);
  endfunction

  function automatic int lvl_base(int l);
    int s = 0;
    for (int k = 0; k < l; k++) s += lvl_nodes(k);
    return s;
  endfunction

  localparam int TOT  = lvl_base(L + 1);
  localparam int LEAF = lvl_base(L);

  function automatic int parent(int i);
    int l = 1;
    while (l < L && lvl_base(l + 1) <= i) l++;
    return lvl_base(l - 1) + (i - lvl_base(l)) / FAN;
  endfunction

  // ---------------- stream steering ----------------
  logic [IDW-1:0] cur;
  logic [AW-1:0]  addr;
  logic           done;
  logic [NT-1:0]  hit;
  logic           active, acc;

  for (genvar k = 0; k < NT; k++) begin : g_id
    assign hit[k] = (cur == IDW'(k + 1));
  end

  assign active    = (cur != '0);
  assign s_tready  = active && ((hit & tgt_full) == '0);
  assign acc       = s_tvalid && s_tready;
  assign wr_en     = {NT{acc}} & hit;
  assign wr_addr   = addr;
  assign wr_data   = s_tdata;
  assign cur_id    = cur;
  assign load_done = done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur  <= '0;
      addr <= '0;
      done <= 1'b0;
    end else if (!active) begin
      if (load_start) begin
        cur  <= IDW'(1);
        addr <= '0;
        done <= 1'b0;
      end
    end else if (acc) begin
      if (s_tlast) begin
        addr <= '0;
        if (cur == IDW'(NT)) begin
          cur  <= '0;
          done <= 1'b1;
        end else begin
          cur <= cur + IDW'(1);
        end
      end else begin
        addr <= addr + AW'(1);
      end
    end
  end

  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && load_start) |=> (cur_id == IDW'(1) && !load_done));
  // R5
  id_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && s_tlast && cur != IDW'(NT)) |=> (cur_id == $past(cur_id) + IDW'(1)));
  // R5
  id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !(s_tvalid && s_tready && s_tlast)) |=> $stable(cur_id));
  // R4
  addr_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && s_tlast) |=> (wr_addr == '0));
  // R4
  addr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !s_tlast) |=> (wr_addr == $past(wr_addr) + AW'(1)));
  // R7
  done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && s_tlast && cur == IDW'(NT)) |=> (load_done && cur_id == '0));
  // R6
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_id == '0) |-> !s_tready);

  // ---------------- local broadcast tree ----------------
  logic          nv  [TOT];
  logic [LW-1:0] nid [TOT];
  logic [DW-1:0] nd  [TOT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TOT; i++) begin
        nv[i]  <= 1'b0;
        nid[i] <= '0;
        nd[i]  <= '0;
      end
    end else begin
      nv[0]  <= gib_valid;
      nid[0] <= gib_lid;
      nd[0]  <= gib_data;
      for (int i = 1; i < TOT; i++) begin
        nv[i]  <= nv[parent(i)];
        nid[i] <= nid[parent(i)];
        nd[i]  <= nd[parent(i)];
      end
    end
  end

  for (genvar j = 0; j < NL; j++) begin : g_leaf
    assign lib_data[j*DW +: DW] = nd[LEAF + j];
    assign lib_we[j] = nv[LEAF + j] && (nid[LEAF + j] == LW'(j + 1));

    // R8
    lib_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lib_we[j] |-> ($past(gib_valid, LAT) && $past(gib_lid, LAT) == LW'(j + 1)));
  end

endmodule

// File: tb/tb_stream_id_router.sv
`timescale 1ns/1ps
module tb_stream_id_router;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_start = 1'b0;
  logic [15:0]   s_tdata = '0;
  logic          s_tvalid = 1'b0;
  logic          s_tlast = 1'b0;
  logic          s_tready;
  logic [65:0]   tgt_full = '0;
  logic [65:0]   wr_en;
  logic [11:0]   wr_addr;
  logic [15:0]   wr_data;
  logic [6:0]    cur_id;
  logic          load_done;
  logic          gib_valid = 1'b0;
  logic [6:0]    gib_lid = '0;
  logic [15:0]   gib_data = '0;
  logic [63:0]   lib_we;
  logic [1023:0] lib_data;

  stream_id_router dut (
    .clk(clk), .rst_n(rst_n), .load_start(load_start),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready),
    .tgt_full(tgt_full), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cur_id(cur_id), .load_done(load_done),
    .gib_valid(gib_valid), .gib_lid(gib_lid), .gib_data(gib_data),
    .lib_we(lib_we), .lib_data(lib_data)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // behavioural reference state
  int          m_id = 0;
  int          m_addr = 0;
  bit          m_done = 0;
  bit          pv [3];
  int          plid [3];
  logic [15:0] pd [3];

  always @(posedge clk or negedge rst_n) begin : model
    bit take;
    if (!rst_n) begin
      m_id = 0; m_addr = 0; m_done = 0;
      for (int i = 0; i < 3; i++) begin pv[i] = 0; plid[i] = 0; pd[i] = '0; end
    end else begin
      take = s_tvalid && (m_id != 0) && !tgt_full[m_id-1];
      if (m_id == 0) begin
        if (load_start) begin m_id = 1; m_done = 0; m_addr = 0; end
      end else if (take) begin
        if (s_tlast) begin
          m_addr = 0;
          if (m_id == 66) begin m_id = 0; m_done = 1; end
          else m_id = m_id + 1;
        end else m_addr = (m_addr + 1) % 4096;
      end
      for (int i = 2; i > 0; i--) begin pv[i] = pv[i-1]; plid[i] = plid[i-1]; pd[i] = pd[i-1]; end
      pv[0] = gib_valid; plid[0] = int'(gib_lid); pd[0] = gib_data;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [1023:0] act, input logic [1023:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    bit          er;
    logic [65:0] ewe;
    logic [63:0] elw;
    er  = (m_id != 0) && !tgt_full[m_id-1];
    ewe = (s_tvalid && er) ? (66'b1 << (m_id - 1)) : 66'b0;
    elw = (pv[2] && plid[2] >= 1 && plid[2] <= 64) ? (64'b1 << (plid[2] - 1)) : 64'b0;
    chk(s_tready === er, "R6 tready", s_tready, er);
    chk(wr_en === ewe, "R1 wr_en", wr_en, ewe);
    chk(wr_addr === 12'(m_addr), "R4 wr_addr", wr_addr, m_addr);
    if (ewe != 0) chk(wr_data === s_tdata, "R3 wr_data", wr_data, s_tdata);
    chk(cur_id === 7'(m_id), "R5 cur_id", cur_id, m_id);
    chk(load_done === m_done, "R7 load_done", load_done, m_done);
    chk(lib_we === elw, "R8 lib_we", lib_we, elw);
    chk(lib_data === {64{pd[2]}}, "R9 lib_data", lib_data, {64{pd[2]}});
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic jitter();
    for (int k = 0; k < 66; k++) tgt_full[k] = ($urandom % 4 == 0);
    gib_valid = $urandom % 2;
    gib_lid   = 7'($urandom % 67);
    gib_data  = 16'($urandom);
  endtask

  task automatic send(input int n, input bit start_last);
    for (int i = 0; i < n; i++) begin
      bit got = 0;
      while (!got) begin
        jitter();
        s_tvalid   = ($urandom % 4 != 0);
        s_tdata    = 16'($urandom);
        s_tlast    = (i == n - 1);
        load_start = start_last && (i == n - 1);
        got = s_tvalid && (m_id != 0) && !tgt_full[m_id-1];
        step();
      end
    end
    s_tvalid = 0; s_tlast = 0; load_start = 0;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    chk(cur_id === 7'd0 && !load_done && !s_tready, "R2 reset idle", cur_id, 0);
    // idle: beats are refused
    for (int i = 0; i < 4; i++) begin
      jitter(); s_tvalid = 1; s_tdata = 16'($urandom); step();
      chk(!s_tready && wr_en == 0, "R6 idle refuse", wr_en, 0);
    end
    s_tvalid = 0;
    load_start = 1; step(); load_start = 0; step();
    chk(cur_id === 7'd1, "R2 start", cur_id, 1);
    send(3, 0);
    load_start = 1; step(); load_start = 0; step();
    chk(cur_id === 7'd2, "R2 start ignored", cur_id, 2);
    for (int w = 0; w < 64; w++) begin
      if (w == 10) send(20, 0);
      else send(1 + w % 3, 0);
    end
    chk(cur_id === 7'd66, "R1 image id", cur_id, 66);
    send(5, 1);
    step();
    chk(load_done && cur_id === 7'd0, "R7 done after image", cur_id, 0);
    for (int i = 0; i < 5; i++) begin jitter(); step(); end
    chk(load_done, "R7 done sticky", load_done, 1);
    load_start = 1; step(); load_start = 0; step();
    chk(!load_done && cur_id === 7'd1, "R2 restart", cur_id, 1);
    send(2, 0);
    send(4, 0);
    for (int i = 0; i < 8; i++) begin jitter(); step(); end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule